// File: doc/BRIEF.md
# Shadow Register Bank with Vertical-Blank Commit

This block is the configuration store of a display pipeline. It keeps two copies of every configuration word. The shadow copy is the one the host writes and reads. The active copy drives the datapath. Host writes never reach the datapath directly. The shadow bank is copied into the active bank in a single clock edge at the start of vertical blanking. This way a frame is never shown with a half-updated configuration.

Software prepares all its changes in the shadow copy, then writes the control word with the load-request bit and the autoload-disable bit both set. The request bit reads back as 1 while the commit waits. It clears itself at the vblank pulse that performs the copy, so software polls it for 0 before it starts the next update. While autoload is enabled (autoload-disable bit clear), every vblank pulse copies the shadow bank, whether or not a request is pending. Reads return the shadow copy, so the host can update single fields by read-modify-write. The shadow words have no defined reset value, so the host clears them by writing zero to each one.

A small commit state machine tracks the request. It has two states:
- `ST_IDLE`: nothing is pending.
- `ST_ARMED`: a commit is waiting for vblank.

Its transitions are:
- `IDLE→ARMED`: a control write with the request bit set.
- `ARMED→IDLE`: a vblank copy with no new request in the same cycle.
- `ARMED→ARMED`: anything else, including a copy that coincides with a new request.
- `IDLE→IDLE`: anything else.

Each copy raises a one-cycle `committed_o` pulse.

Top module: `shadow_commit_bank`

## Requirements
- R1: After reset, `active_o` is all zero, `committed_o` is 0, and the control word (address NUM_REGS) reads 0.
- R2: A host write to a bank address (0 to NUM_REGS-1) changes only the shadow copy. A read of that address returns the written value, and `active_o` does not change without a vblank pulse.
- R3: The control word sits at address NUM_REGS. Bit 0 is the load request and bit 1 is autoload-disable. Writing bit 0 as 1 sets the request, and writing bit 0 as 0 does not cancel a pending request. Bit 1 takes the written value. A read returns bit 0 as the pending flag and bit 1 as the autoload-disable flag.
- R4: With autoload disabled and no request pending, a vblank pulse leaves `active_o` unchanged and raises no `committed_o`.
- R5: With a request pending, a vblank pulse copies the whole shadow bank into `active_o` at that clock edge. In the next cycle `committed_o` is 1 and the request bit reads 0.
- R6: With autoload enabled, every vblank pulse copies the shadow bank and raises `committed_o`, with no request needed.
- R7: A host bank write in the same cycle as a copying vblank pulse updates the shadow copy but is not part of that copy.
- R8: A control write that sets the request in the same cycle as a vblank pulse (autoload disabled, idle) starts no copy. The request stays pending and is served by the following vblank pulse.
- R9: Every bank word stores any written value, including zero, independently of the other words. Addresses above NUM_REGS read 0, and writes to them have no effect.
- R10: `committed_o` is high for exactly one cycle per copy, and only in the cycle after a vblank pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | ADDR_W | Host word address (bank words, then control word) |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data (shadow copy or control word), combinational |
| vblank_i | input | 1 | One-cycle pulse at vertical blanking start |
| active_o | output | NUM_REGS*DATA_W | Active configuration, word i at bits i*DATA_W upward |
| committed_o | output | 1 | One-cycle pulse after each shadow-to-active copy |

## Verification
The bench builds the block with NUM_REGS=8 and DATA_W=16, which puts the control word at address 8 and gives a 4-bit address. That is small enough to compare every active word after every step, and to reach the unused addresses 9 to 15. The collision cases (a bank write or a commit request landing in the vblank cycle) are driven on exact cycles, so the edge-aligned copy can be observed.

// File: rtl/sbank_pkg.sv
package sbank_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_ARMED = 1'b1
    } commit_state_e;

    localparam int CTRL_LOAD_BIT    = 0;
    localparam int CTRL_AUTOOFF_BIT = 1;
endpackage

// File: rtl/sbank_shadow.sv
module sbank_shadow #(
    parameter int NUM_REGS = 16,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 5
) (
    input  logic                       clk,
    input  logic                       bank_we,
    input  logic [ADDR_W-1:0]          bank_addr,
    input  logic [DATA_W-1:0]          bank_wdata,
    output logic [NUM_REGS*DATA_W-1:0] shadow_flat
);
    // Shadow words carry no reset value; the host clears them explicitly.
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
        logic [DATA_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (bank_we && bank_addr == ADDR_W'(i))
                word_q <= bank_wdata;
        end
        assign shadow_flat[i*DATA_W +: DATA_W] = word_q;
    end
endmodule

// File: rtl/sbank_active.sv
module sbank_active #(
    parameter int NUM_REGS = 16,
    parameter int DATA_W   = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load_en,
    input  logic [NUM_REGS*DATA_W-1:0] shadow_flat,
    output logic [NUM_REGS*DATA_W-1:0] active_flat
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
        logic [DATA_W-1:0] word_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                word_q <= '0;
            else if (load_en)
                word_q <= shadow_flat[i*DATA_W +: DATA_W];
        end
        assign active_flat[i*DATA_W +: DATA_W] = word_q;
    end
endmodule

// File: rtl/sbank_commit_fsm.sv
module sbank_commit_fsm
    import sbank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_we,
    input  logic req_bit,
    input  logic autooff_bit,
    input  logic vblank_i,
    output logic copy_fire,
    output logic pending,
    output logic autooff,
    output logic committed
);
    commit_state_e state_q, state_d;
    logic          autooff_q;
    logic          committed_q;
    logic          set_req;

    assign set_req = ctrl_we && req_bit;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (set_req)
                    state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (copy_fire && !set_req)
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        pending   = (state_q == ST_ARMED);
        autooff   = autooff_q;
        copy_fire = vblank_i && (pending || !autooff_q);
        committed = committed_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            autooff_q   <= 1'b0;
            committed_q <= 1'b0;
        end else begin
            if (ctrl_we)
                autooff_q <= autooff_bit;
            committed_q <= copy_fire;
        end
    end
endmodule

// File: rtl/shadow_commit_bank.sv
module shadow_commit_bank
    import sbank_pkg::*;
#(
    parameter int NUM_REGS = 16,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = $clog2(NUM_REGS + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       host_we,
    input  logic [ADDR_W-1:0]          host_addr,
    input  logic [DATA_W-1:0]          host_wdata,
    output logic [DATA_W-1:0]          host_rdata,
    input  logic                       vblank_i,
    output logic [NUM_REGS*DATA_W-1:0] active_o,
    output logic                       committed_o
);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_REGS);

    logic                       in_bank;
    logic                       bank_we;
    logic                       ctrl_we;
    logic                       copy_fire;
    logic                       pending;
    logic                       autooff;
    logic [NUM_REGS*DATA_W-1:0] shadow_flat;

    assign in_bank = (host_addr < CTRL_ADDR);
    assign bank_we = host_we && in_bank;
    assign ctrl_we = host_we && (host_addr == CTRL_ADDR);

    sbank_shadow #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W)
    ) shadow_i (
        .clk         (clk),
        .bank_we     (bank_we),
        .bank_addr   (host_addr),
        .bank_wdata  (host_wdata),
        .shadow_flat (shadow_flat)
    );

    sbank_active #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W)
    ) active_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_en     (copy_fire),
        .shadow_flat (shadow_flat),
        .active_flat (active_o)
    );

    sbank_commit_fsm fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_we     (ctrl_we),
        .req_bit     (host_wdata[CTRL_LOAD_BIT]),
        .autooff_bit (host_wdata[CTRL_AUTOOFF_BIT]),
        .vblank_i    (vblank_i),
        .copy_fire   (copy_fire),
        .pending     (pending),
        .autooff     (autooff),
        .committed   (committed_o)
    );

    // Read path: shadow words, then the control word, zero elsewhere
    always_comb begin
        host_rdata = '0;
        if (in_bank) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (host_addr == ADDR_W'(i))
                    host_rdata = shadow_flat[i*DATA_W +: DATA_W];
            end
        end else if (host_addr == CTRL_ADDR) begin
            host_rdata[CTRL_LOAD_BIT]    = pending;
            host_rdata[CTRL_AUTOOFF_BIT] = autooff;
        end
    end
endmodule

// File: rtl/sbank_checker.sv
module sbank_checker #(
    parameter int NUM_REGS = 16,
    parameter int DATA_W   = 32
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       vblank_i,
    input logic                       committed_o,
    input logic                       pending,
    input logic                       autooff,
    input logic [NUM_REGS*DATA_W-1:0] active_o,
    input logic [NUM_REGS*DATA_W-1:0] shadow_flat
);
    // R2: active copy only moves on a vblank cycle
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !vblank_i |=> $stable(active_o));

    // R4: disabled autoload and nothing pending means no transfer
    p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (vblank_i && !pending && autooff) |=> (!committed_o && $stable(active_o)));

    // R5: pending commit copies the shadow bank at the vblank edge
    p_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (vblank_i && pending) |=> (committed_o && active_o == $past(shadow_flat)));

    // R6: autoload copies on every vblank
    p_autoload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (vblank_i && !autooff) |=> (committed_o && active_o == $past(shadow_flat)));

    // R10: pulse only follows a vblank cycle
    p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        committed_o |-> $past(vblank_i));
endmodule

bind shadow_commit_bank sbank_checker #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .vblank_i    (vblank_i),
    .committed_o (committed_o),
    .pending     (pending),
    .autooff     (autooff),
    .active_o    (active_o),
    .shadow_flat (shadow_flat)
);

// File: tb/shadow_commit_bank_tb.sv
module shadow_commit_bank_tb_top;
    localparam int N  = 8;
    localparam int W  = 16;
    localparam int AW = 4;
    localparam logic [AW-1:0] CTRL = AW'(N);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            host_we = 1'b0;
    logic [AW-1:0]   host_addr = '0;
    logic [W-1:0]    host_wdata = '0;
    logic [W-1:0]    host_rdata;
    logic            vblank_i = 1'b0;
    logic [N*W-1:0]  active_o;
    logic            committed_o;

    int checks = 0;
    int fails  = 0;
    logic [W-1:0] exp_sh  [N];
    logic [W-1:0] exp_act [N];

    always #5 clk = ~clk;

    shadow_commit_bank #(.NUM_REGS(N), .DATA_W(W), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .vblank_i(vblank_i),
        .active_o(active_o), .committed_o(committed_o));

    task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        step();
        host_we = 1'b0;
        if (a < CTRL) exp_sh[a] = d;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [W-1:0] d);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    task automatic chk_active(input string tag);
        for (int i = 0; i < N; i++)
            chk(tag, active_o[i*W +: W], exp_act[i]);
    endtask

    task automatic vb_pulse();
        vblank_i = 1'b1;
        step();
        vblank_i = 1'b0;
    endtask

    task automatic t_reset();
        logic [W-1:0] d;
        for (int i = 0; i < N; i++) exp_act[i] = '0;
        chk_active("R1 active zero");
        chk("R1 committed", W'(committed_o), '0);
        rd(CTRL, d);
        chk("R1 control", d, '0);
    endtask

    task automatic t_zero_region();
        logic [W-1:0] d;
        wr(CTRL, 16'h0002);                      // disable autoload first
        for (int i = 0; i < N; i++) wr(AW'(i), W'(16'hA500 + i));
        for (int i = 0; i < N; i++) wr(AW'(i), '0);
        for (int i = 0; i < N; i++) begin
            rd(AW'(i), d);
            chk("R9 zeroed word", d, '0);
        end
        wr(AW'(3), 16'h1234);
        rd(AW'(2), d); chk("R9 neighbour", d, '0);
        rd(AW'(3), d); chk("R9 word", d, 16'h1234);
        wr(AW'(12), 16'hFFFF);
        rd(AW'(12), d); chk("R9 unused addr", d, '0);
        for (int i = 0; i < N; i++) begin
            rd(AW'(i), d); chk("R9 no alias", d, exp_sh[i]);
        end
    endtask

    task automatic t_shadow_only();
        logic [W-1:0] d;
        wr(AW'(0), 16'hBEEF);
        wr(AW'(7), 16'h0F0F);
        rd(AW'(0), d); chk("R2 read shadow", d, 16'hBEEF);
        rd(AW'(7), d); chk("R2 read shadow", d, 16'h0F0F);
        step(); step();
        chk_active("R2 active untouched");
        chk("R2 no pulse", W'(committed_o), '0);
    endtask

    task automatic t_no_autoload_hold();
        vb_pulse();
        chk("R4 no pulse", W'(committed_o), '0);
        chk_active("R4 active held");
    endtask

    task automatic t_ctrl_fields();
        logic [W-1:0] d;
        wr(CTRL, 16'h0003);
        rd(CTRL, d); chk("R3 pending+autooff", d, 16'h0003);
        wr(CTRL, 16'h0002);
        rd(CTRL, d); chk("R3 no cancel", d, 16'h0003);
        step(); step();
        chk_active("R3 waits for vblank");
    endtask

    task automatic t_commit();
        logic [W-1:0] d;
        vb_pulse();
        for (int i = 0; i < N; i++) exp_act[i] = exp_sh[i];
        chk("R5 pulse", W'(committed_o), 1);
        chk_active("R5 copied");
        rd(CTRL, d); chk("R5 request cleared", d, 16'h0002);
        step();
        chk("R10 one cycle", W'(committed_o), '0);
    endtask

    task automatic t_collide();
        wr(AW'(5), 16'h5555);
        wr(CTRL, 16'h0003);
        host_we = 1'b1; host_addr = AW'(5); host_wdata = 16'h6666;
        vblank_i = 1'b1;
        step();
        host_we = 1'b0; vblank_i = 1'b0;
        for (int i = 0; i < N; i++) exp_act[i] = exp_sh[i];
        exp_sh[5] = 16'h6666;
        chk("R7 pulse", W'(committed_o), 1);
        chk("R7 old value active", active_o[5*W +: W], 16'h5555);
        chk_active("R7 copy");
    endtask

    task automatic t_commit_in_vblank();
        logic [W-1:0] d;
        step();
        host_we = 1'b1; host_addr = CTRL; host_wdata = 16'h0003;
        vblank_i = 1'b1;
        step();
        host_we = 1'b0; vblank_i = 1'b0;
        chk("R8 no pulse", W'(committed_o), '0);
        rd(CTRL, d); chk("R8 still pending", d, 16'h0003);
        chk_active("R8 active held");
        vb_pulse();
        for (int i = 0; i < N; i++) exp_act[i] = exp_sh[i];
        chk("R8 served next", W'(committed_o), 1);
        chk("R8 new value active", active_o[5*W +: W], 16'h6666);
    endtask

    task automatic t_autoload();
        wr(CTRL, 16'h0000);
        wr(AW'(1), 16'hC0DE);
        vb_pulse();
        for (int i = 0; i < N; i++) exp_act[i] = exp_sh[i];
        chk("R6 pulse", W'(committed_o), 1);
        chk_active("R6 copy");
        wr(AW'(1), 16'hD00D);
        chk("R10 low between", W'(committed_o), '0);
        vb_pulse();
        for (int i = 0; i < N; i++) exp_act[i] = exp_sh[i];
        chk("R6 second pulse", W'(committed_o), 1);
        chk("R6 second copy", active_o[1*W +: W], 16'hD00D);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) exp_sh[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        t_reset();
        t_zero_region();
        t_shadow_only();
        t_no_autoload_hold();
        t_ctrl_fields();
        t_commit();
        t_collide();
        t_commit_in_vblank();
        t_autoload();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule